// File: doc/BRIEF.md
# Alarm-Aligned Fixed-Interval Pulse Generator

This block turns the nominal tick of a free-running nanosecond time counter into one to three periodic pulse trains, for example a once-per-second marker. The time counter lives outside the block; its value and a strobe that marks each step of `TICK_NS` nanoseconds arrive as inputs. Each channel holds a period word in nanoseconds, written in "interval minus one tick" form. A channel whose word is P repeats every floor(P / TICK_NS) + 1 ticks, and each pulse stays high for one output-clock period. The output clock is the tick divided by a 16-bit prescaler.

The trains do not run from reset. After the timer enable is raised they wait for the running time to equal a programmed alarm value on a tick, so their phase lands on a chosen boundary. Software normally sets the alarm to a whole-second boundary minus one tick. A start-by-alarm control can be cleared to start at once instead. A realignment-disable control decides whether later alarm matches re-phase trains that are already running. Every pulse sets a sticky event flag, and a write-one-to-clear input clears it.

Top module: `fipulse_gen`

## Requirements
- R1: While reset is asserted, and in the cycle after it, every pulse output and every event bit is 0.
- R2: With start-by-alarm set, no pulse appears before a tick on which `time_i` equals `alarm_i` while enabled. That tick arms all channels, and each channel's first pulse rises on the next tick.
- R3: Once armed, channel c with period word P pulses on every (floor(P / TICK_NS) + 1)-th tick, counted from its first pulse.
- R4: Each pulse stays high for `prsc_i` ticks, or for 1 tick when the prescaler is 0.
- R5: With start-by-alarm clear, the first tick with the enable set arms the channels, whatever the alarm value.
- R6: While the channels are running, a later alarm match on a tick re-arms them (new first pulse on the next tick) when realignment-disable is 0, and it has no effect when that control is 1.
- R7: The prescaler and period words are taken only in cycles where the enable is low. Changes made while enabled do not affect the pulse trains until the enable has been dropped and raised again.
- R8: Clearing the enable disarms every channel and forces every pulse output low from the next cycle. After the enable is raised again, no pulse appears until a new arming event.
- R9: A pulse of channel 0, 1 or 2 sets event bit 7, 6 or 5. Unused bits read 0. A bit stays set until a 1 is written to the same bit of `evt_clr_i`, and a pulse in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Timer enable; low disarms and allows new settings |
| align_en_i | input | 1 | 1: start on alarm match; 0: start on first enabled tick |
| realign_dis_i | input | 1 | 1: ignore alarm matches once running |
| tick_i | input | 1 | One time-counter step of TICK_NS ns |
| time_i | input | TIME_W | Current time in ns |
| alarm_i | input | TIME_W | Arming alarm time in ns |
| prsc_i | input | PRSC_W | Output-clock prescaler (pulse width in ticks) |
| per_i | input | NCH*PER_W | Period words, channel 0 in the low bits |
| evt_clr_i | input | 8 | Write-one-to-clear for event bits |
| pulse_o | output | NCH | Pulse outputs, one per channel |
| evt_o | output | 8 | Sticky event flags (bits 7..5) |

## Verification
Four settings of the prescaler and the period words are run from an alarm start. They include a zero prescaler, a zero period word (a pulse on every tick), and a word that is not a multiple of the tick. Together they separate the floor-plus-one period rule from an off-by-one period and from a wrong pulse width. Directed runs compare start on the first enabled tick with alarm start. An alarm match is placed in the middle of a period so that realignment and no realignment give different pulse positions. Period words are changed while enabled to show they are not taken until re-enable. The enable is dropped during a pulse, and event clears are issued while pulses fire in the same cycle.

// File: rtl/fipulse_pkg.sv
package fipulse_pkg;

    // Arming state of the whole pulse generator
    typedef enum logic [1:0] {
        ARM_OFF,
        ARM_WAIT,
        ARM_RUN
    } arm_state_e;

    // Per-tick command broadcast to every channel
    typedef struct packed {
        logic clear;   // timer disabled: drop everything
        logic load;    // arm or re-arm: fire on the next tick
        logic step;    // ordinary tick while running
    } chan_cmd_t;

    localparam int EVT_W   = 8;
    localparam int EVT_TOP = 7;

    // Event bit position owned by a channel
    function automatic int evt_pos(input int ch);
        return EVT_TOP - ch;
    endfunction

endpackage

// File: rtl/fipulse_arm.sv
module fipulse_arm
    import fipulse_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enable_i,
    input  logic      tick_i,
    input  logic      align_en_i,
    input  logic      realign_dis_i,
    input  logic      alarm_hit_i,
    output chan_cmd_t cmd_o
);

    arm_state_e st_q;
    logic       running;
    logic       start_now;
    logic       realign_now;
    logic       load_now;

    always_comb begin
        running     = (st_q == ARM_RUN);
        start_now   = !running && (!align_en_i || alarm_hit_i);
        realign_now = running && alarm_hit_i && !realign_dis_i;
        load_now    = enable_i && tick_i && (start_now || realign_now);
    end

    always_comb begin
        cmd_o.clear = !enable_i;
        cmd_o.load  = load_now;
        cmd_o.step  = enable_i && tick_i && running && !load_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ARM_OFF;
        end else if (!enable_i) begin
            st_q <= ARM_OFF;
        end else if (load_now) begin
            st_q <= ARM_RUN;
        end else if (st_q == ARM_OFF) begin
            st_q <= ARM_WAIT;
        end
    end

endmodule

// File: rtl/fipulse_chan.sv
module fipulse_chan
    import fipulse_pkg::*;
#(
    parameter int PER_W   = 32,
    parameter int PRSC_W  = 16,
    parameter int TICK_NS = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  chan_cmd_t         cmd_i,
    input  logic [PER_W-1:0]  period_i,
    input  logic [PRSC_W-1:0] width_i,
    output logic              fire_o,
    output logic              pulse_o
);

    localparam logic [PER_W-1:0] STEP = PER_W'(TICK_NS);

    logic [PER_W-1:0]  cnt_q;
    logic [PRSC_W-1:0] wid_q;
    logic              expire;

    // Remaining time has reached zero or below within this tick
    assign expire  = (cnt_q < STEP);
    assign fire_o  = cmd_i.step && expire;
    assign pulse_o = (wid_q != '0);

    always_ff @(posedge clk) begin
        if (rst || cmd_i.clear) begin
            cnt_q <= '0;
            wid_q <= '0;
        end else if (cmd_i.load) begin
            cnt_q <= '0;
            if (wid_q != '0) wid_q <= wid_q - 1'b1;
        end else if (cmd_i.step) begin
            if (expire) begin
                cnt_q <= period_i;
                wid_q <= width_i;
            end else begin
                cnt_q <= cnt_q - STEP;
                if (wid_q != '0) wid_q <= wid_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/fipulse_gen.sv
module fipulse_gen
    import fipulse_pkg::*;
#(
    parameter int NCH     = 3,
    parameter int TICK_NS = 10,
    parameter int TIME_W  = 64,
    parameter int PER_W   = 32,
    parameter int PRSC_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable_i,
    input  logic                 align_en_i,
    input  logic                 realign_dis_i,
    input  logic                 tick_i,
    input  logic [TIME_W-1:0]    time_i,
    input  logic [TIME_W-1:0]    alarm_i,
    input  logic [PRSC_W-1:0]    prsc_i,
    input  logic [NCH*PER_W-1:0] per_i,
    input  logic [EVT_W-1:0]     evt_clr_i,
    output logic [NCH-1:0]       pulse_o,
    output logic [EVT_W-1:0]     evt_o
);

    localparam int PER_BUS = NCH * PER_W;

    logic [PRSC_W-1:0]  prsc_q;
    logic [PRSC_W-1:0]  width;
    logic [PER_BUS-1:0] per_q;
    logic               alarm_hit;
    chan_cmd_t          cmd;
    logic [NCH-1:0]     fire;
    logic [EVT_W-1:0]   evt_q;
    logic [EVT_W-1:0]   evt_set;

    // Settings are only taken while the timer is disabled
    always_ff @(posedge clk) begin
        if (rst) begin
            prsc_q <= '0;
            per_q  <= '0;
        end else if (!enable_i) begin
            prsc_q <= prsc_i;
            per_q  <= per_i;
        end
    end

    assign width     = (prsc_q == '0) ? PRSC_W'(1) : prsc_q;
    assign alarm_hit = (time_i == alarm_i);

    fipulse_arm u_arm (
        .clk          (clk),
        .rst          (rst),
        .enable_i     (enable_i),
        .tick_i       (tick_i),
        .align_en_i   (align_en_i),
        .realign_dis_i(realign_dis_i),
        .alarm_hit_i  (alarm_hit),
        .cmd_o        (cmd)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        fipulse_chan #(
            .PER_W  (PER_W),
            .PRSC_W (PRSC_W),
            .TICK_NS(TICK_NS)
        ) u_chan (
            .clk     (clk),
            .rst     (rst),
            .cmd_i   (cmd),
            .period_i(per_q[c*PER_W +: PER_W]),
            .width_i (width),
            .fire_o  (fire[c]),
            .pulse_o (pulse_o[c])
        );
    end

    always_comb begin
        evt_set = '0;
        for (int c = 0; c < NCH; c++) begin
            evt_set[evt_pos(c)] = fire[c];
        end
    end

    // Sticky flags, write-one-to-clear, a new pulse wins
    always_ff @(posedge clk) begin
        if (rst) evt_q <= '0;
        else     evt_q <= (evt_q & ~evt_clr_i) | evt_set;
    end

    assign evt_o = evt_q;

endmodule

// File: rtl/fipulse_chk.sv
module fipulse_chk #(
    parameter int NCH = 3
) (
    input logic           clk,
    input logic           rst,
    input logic           enable_i,
    input logic           tick_i,
    input logic [NCH-1:0] pulse_o,
    input logic [7:0]     evt_o
);

    localparam logic [7:0] USED = 8'(8'hFF << (8 - NCH));

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (pulse_o == '0 && evt_o == '0));

    // R8
    a_r8_disable_low: assert property (@(posedge clk) disable iff (rst)
        !enable_i |=> (pulse_o == '0));

    // R9
    a_r9_unused_evt_zero: assert property (@(posedge clk) disable iff (rst)
        (evt_o & ~USED) == 8'h00);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // R9
        a_r9_evt_on_pulse: assert property (@(posedge clk) disable iff (rst)
            $rose(pulse_o[c]) |-> evt_o[7 - c]);
        // R2
        a_r2_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
            $rose(pulse_o[c]) |-> ($past(tick_i) && $past(enable_i)));
    end

endmodule

bind fipulse_gen fipulse_chk #(.NCH(NCH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .enable_i(enable_i),
    .tick_i  (tick_i),
    .pulse_o (pulse_o),
    .evt_o   (evt_o)
);

// File: tb/fipulse_gen_test.sv
`timescale 1ns/1ps
module fipulse_gen_test;

    localparam int NCH  = 3;
    localparam int TICK = 10;
    // prescaler, period ch0, ch1, ch2, cycles to run
    localparam int CFG [4][5] = '{
        '{2, 50, 30, 90, 40},
        '{1, 20, 40,  0, 20},
        '{0, 55, 15, 75, 40},
        '{3, 70, 65, 35, 40}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable_i = 1'b0;
    logic        align_en_i = 1'b1;
    logic        realign_dis_i = 1'b0;
    logic        tick_i = 1'b1;
    logic [63:0] time_i = 64'd0;
    logic [63:0] alarm_i = 64'd0;
    logic [15:0] prsc_i = 16'd0;
    logic [95:0] per_i = 96'd0;
    logic [7:0]  evt_clr_i = 8'h00;
    logic [2:0]  pulse_o;
    logic [7:0]  evt_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // Reference model state, built from the requirements
    bit         m_run = 0;
    int         m_j = 0;
    int         m_per [3] = '{0, 0, 0};
    int         m_prsc = 0;
    logic [7:0] m_evt = 8'h00;

    always #4 clk = ~clk;

    fipulse_gen uut (
        .clk          (clk),
        .rst          (rst),
        .enable_i     (enable_i),
        .align_en_i   (align_en_i),
        .realign_dis_i(realign_dis_i),
        .tick_i       (tick_i),
        .time_i       (time_i),
        .alarm_i      (alarm_i),
        .prsc_i       (prsc_i),
        .per_i        (per_i),
        .evt_clr_i    (evt_clr_i),
        .pulse_o      (pulse_o),
        .evt_o        (evt_o)
    );

    task automatic check(input string rq, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic int nper(input int c);
        return m_per[c] / TICK + 1;
    endfunction

    function automatic int mwid();
        return (m_prsc == 0) ? 1 : m_prsc;
    endfunction

    // One clock: update model from the inputs, pass the edge, compare
    task automatic cyc(input string rq);
        logic [7:0] fb;
        logic [2:0] expp;
        bit         match;
        match = (time_i == alarm_i);
        fb = 8'h00;
        if (rst) begin
            m_run = 0; m_j = 0; m_evt = 8'h00; m_prsc = 0;
            for (int c = 0; c < 3; c++) m_per[c] = 0;
        end else begin
            if (!enable_i) begin
                m_prsc = int'(prsc_i);
                for (int c = 0; c < 3; c++) m_per[c] = int'(per_i[c*32 +: 32]);
            end
            m_evt = m_evt & ~evt_clr_i;
            if (!enable_i) begin
                m_run = 0;
            end else if (tick_i && ((!m_run && (!align_en_i || match)) ||
                                    (m_run && match && !realign_dis_i))) begin
                m_run = 1; m_j = 0;
            end else if (m_run && tick_i) begin
                m_j++;
                for (int c = 0; c < 3; c++)
                    if (((m_j - 1) % nper(c)) == 0) fb[7 - c] = 1'b1;
            end
            m_evt = m_evt | fb;
        end
        @(negedge clk);
        for (int c = 0; c < 3; c++)
            expp[c] = m_run && (m_j >= 1) && (((m_j - 1) % nper(c)) < mwid());
        check(rq, "pulse", {5'b0, pulse_o}, {5'b0, expp});
        check(rq, "events", evt_o, m_evt);
        if (tick_i) time_i = time_i + 64'(TICK);
    endtask

    task automatic setup(input int pr, input int p0, input int p1, input int p2);
        enable_i  = 1'b0;
        prsc_i    = 16'(pr);
        per_i     = {32'(p2), 32'(p1), 32'(p0)};
        evt_clr_i = 8'hFF;
        cyc("R7");
        evt_clr_i = 8'h00;
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        cyc("R1");
        cyc("R1");
        rst = 1'b0;

        // Table walk: alarm start, periods, widths, events (R2 R3 R4 R9)
        for (int k = 0; k < 4; k++) begin
            setup(CFG[k][0], CFG[k][1], CFG[k][2], CFG[k][3]);
            alarm_i  = time_i + 64'(3 * TICK);
            enable_i = 1'b1;
            for (int n = 0; n < CFG[k][4]; n++) cyc("R2/R3/R4/R9");
        end

        // R5: start without alarm
        setup(1, 50, 30, 20);
        align_en_i = 1'b0;
        alarm_i    = 64'd5;
        enable_i   = 1'b1;
        for (int n = 0; n < 15; n++) cyc("R5");
        align_en_i = 1'b1;

        // R6: realignment mid-period, then with realignment disabled
        setup(1, 50, 50, 50);
        alarm_i  = time_i + 64'(3 * TICK);
        enable_i = 1'b1;
        for (int g = 0; g < 100 && !(m_run && m_j == 7); g++) cyc("R6");
        alarm_i = time_i;
        for (int n = 0; n < 14; n++) cyc("R6");
        for (int g = 0; g < 100 && m_j != 7; g++) cyc("R6");
        realign_dis_i = 1'b1;
        alarm_i = time_i;
        for (int n = 0; n < 14; n++) cyc("R6");

        // R7: settings changed while enabled are not taken
        prsc_i = 16'd2;
        per_i  = {32'd20, 32'd20, 32'd20};
        for (int n = 0; n < 20; n++) cyc("R7");
        realign_dis_i = 1'b0;
        enable_i = 1'b0;
        cyc("R7");
        alarm_i  = time_i + 64'(2 * TICK);
        enable_i = 1'b1;
        for (int n = 0; n < 20; n++) cyc("R7");

        // R8: drop enable during a pulse, then re-enable with a past alarm
        for (int g = 0; g < 50 && pulse_o == 3'b000; g++) cyc("R8");
        enable_i = 1'b0;
        cyc("R8");
        enable_i = 1'b1;
        for (int n = 0; n < 15; n++) cyc("R8");

        // R9: write-one-to-clear, pulse wins over clear
        setup(1, 0, 20, 50);
        alarm_i  = time_i + 64'(2 * TICK);
        enable_i = 1'b1;
        for (int n = 0; n < 8; n++) cyc("R9");
        evt_clr_i = 8'h80; cyc("R9");
        evt_clr_i = 8'h40; cyc("R9");
        evt_clr_i = 8'h20; cyc("R9");
        evt_clr_i = 8'h00;
        for (int n = 0; n < 5; n++) cyc("R9");
        enable_i  = 1'b0;
        evt_clr_i = 8'hFF; cyc("R9");
        evt_clr_i = 8'h00; cyc("R9");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule